// File: doc/BRIEF.md
# Write-Buffered Atomic Register Stage

This block sits between a register decoder and the register storage of a set of 64-bit control registers reached over a 32-bit write bus with byte strobes. A register can be configured to apply writes at once, or to collect them in a private staging buffer and apply them only when a trigger fires. Several registers can then change together on one clock edge, and a 64-bit value written as two halves can land in a single step.

Each register picks its trigger with a 2-bit mode code. A buffered register commits on a write to its own upper word, on any write to a shared trigger register, or while an external pin is at its active level. Only the bits actually written since the last commit change at commit time. The software-access and software-modify pulses follow the commit, not the bus write. Reads always return the committed contents.

The write port is a valid/ready channel. The block never applies back-pressure: ready is held high, and a write is taken on every clock edge where valid is high. Nothing is taken while valid is low.

Top module: `wbuf_regstage`

## Requirements
- R1: A register in a buffered mode (codes 1, 2, 3) keeps its committed value across software writes until its trigger fires.
- R2: Mode 1 (own upper word): a write to word address 2k+1 commits register k. It loads the buffered lower-word data and this write's upper-word data on the same edge. The new value is visible on `reg_q_o` in the cycle after that edge.
- R3: Mode 2 (trigger register): any accepted write to word address 2*NREG commits every mode-2 register with pending data on the same edge, whatever its strobes. The trigger register itself stores the strobed bytes at once and reads back at that address. A write to a mode-2 register's upper word does not commit it.
- R4: Mode 3 (external pin): the external input at its active level (`EXT_ACT_HIGH`, default 0 = active low) on a clock edge commits the register. A write to that register on the same edge is part of the commit. The value is visible in the following cycle, and the inactive level commits nothing.
- R5: A trigger that arrives when the register has received no write since its last commit changes nothing and produces no pulse.
- R6: Strobe bit i covers data bits 8i+7..8i of the addressed word. At commit, only bits written since the last commit change. A later write to the same bits before the commit replaces the earlier data.
- R7: `sw_acc_o[k]` is high for exactly one cycle, the first cycle in which a commit is visible. It is never high on the cycle after a buffered write that did not commit. `sw_mod_o[k]` is high in that cycle only if at least one strobe bit was set.
- R8: Mode 0 (unbuffered): a write is applied on its own edge and is visible in the next cycle, with the pulses.
- R9: `rd_data_o` (combinational) returns bits 31:0 of register k at word 2k, bits 63:32 at word 2k+1, the trigger register at word 2*NREG, and zero elsewhere. Staged data is never returned.
- R10: Reset (active low, asynchronous) clears all registers, the trigger register, the staging buffers, pending state and pulses. A trigger after reset commits nothing that was staged before it.
- R11: `wr_ready_o` is always high, and a write with `wr_valid_i` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write request valid |
| wr_ready_o | output | 1 | Write request ready (always high) |
| wr_addr_i | input | AW | Write word address |
| wr_data_i | input | 32 | Write data |
| wr_strb_i | input | 4 | Byte write strobes |
| rd_addr_i | input | AW | Read word address |
| rd_data_o | output | 32 | Read data (committed values) |
| ext_trig_i | input | 1 | External commit trigger |
| go_q_o | output | 32 | Trigger register contents |
| reg_q_o | output | NREG*64 | Committed register values, register k at bits 64k+63..64k |
| sw_acc_o | output | NREG | Per-register software-access pulse |
| sw_mod_o | output | NREG | Per-register software-modify pulse |

## Verification
Full two-word writes against single-byte and overlapping partial writes show whether merging is done per written bit and whether a later write replaces an earlier one. Triggers sent to empty buffers, to the upper word of a mode-2 register, and through an inactive pin level show that only the configured trigger with pending data commits. An external trigger that arrives with a write on the same edge, a zero-strobe write, a write without valid, and a reset with data still staged cover the remaining edges of commit timing and pulse generation. Register-group commits are checked on both mode-2 registers in the same cycle.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int BUS_W  = 32;
  localparam int STRB_W = BUS_W / 8;
  localparam int REG_W  = 2 * BUS_W;

  typedef enum logic [1:0] {
    TRIG_NONE    = 2'd0,
    TRIG_OWN_TOP = 2'd1,
    TRIG_GO_REG  = 2'd2,
    TRIG_EXT_PIN = 2'd3
  } trig_mode_e;

  typedef logic [REG_W-1:0] reg_word_t;

  function automatic logic [BUS_W-1:0] strb_to_bits(input logic [STRB_W-1:0] s);
    logic [BUS_W-1:0] b;
    for (int i = 0; i < STRB_W; i++) b[8*i +: 8] = {8{s[i]}};
    return b;
  endfunction
endpackage

// File: rtl/wbuf_decode.sv
module wbuf_decode #(
  parameter int NREG = 5,
  parameter int AW   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_valid_i,
  input  logic [AW-1:0]   wr_addr_i,
  output logic [NREG-1:0] lo_hit_o,
  output logic [NREG-1:0] hi_hit_o,
  output logic            go_hit_o
);
  localparam int GO_ADDR = 2 * NREG;

  for (genvar k = 0; k < NREG; k++) begin : g_hit
    assign lo_hit_o[k] = wr_valid_i && (wr_addr_i == AW'(2 * k));
    assign hi_hit_o[k] = wr_valid_i && (wr_addr_i == AW'(2 * k + 1));
  end
  assign go_hit_o = wr_valid_i && (wr_addr_i == AW'(GO_ADDR));

  // R11: a write reaches at most one target, and none without valid
  p_single_target_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lo_hit_o, hi_hit_o, go_hit_o}));
  p_no_hit_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |-> ({lo_hit_o, hi_hit_o, go_hit_o} == '0));
endmodule

// File: rtl/wbuf_slot.sv
module wbuf_slot
  import wbuf_pkg::*;
#(
  parameter trig_mode_e MODE = TRIG_OWN_TOP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lo_wr_i,
  input  logic              hi_wr_i,
  input  logic [BUS_W-1:0]  data_i,
  input  logic [STRB_W-1:0] strb_i,
  input  logic              go_i,
  input  logic              ext_i,
  output reg_word_t         q_o,
  output logic              acc_o,
  output logic              mod_o
);
  localparam bit BUFFERED = (MODE != TRIG_NONE);

  logic             any_wr, fire, commit, touched_q;
  logic [BUS_W-1:0] byte_bits;
  reg_word_t        in_data, in_mask, stage_q, mask_q, data_now, mask_now;

  assign byte_bits = strb_to_bits(strb_i);
  assign any_wr    = lo_wr_i | hi_wr_i;
  assign in_data   = {data_i, data_i};
  assign in_mask   = {hi_wr_i ? byte_bits : {BUS_W{1'b0}},
                      lo_wr_i ? byte_bits : {BUS_W{1'b0}}};
  assign mask_now  = mask_q | in_mask;
  assign data_now  = (stage_q & ~in_mask) | (in_data & in_mask);

  always_comb begin
    case (MODE)
      TRIG_OWN_TOP: fire = hi_wr_i;
      TRIG_GO_REG:  fire = go_i;
      TRIG_EXT_PIN: fire = ext_i;
      default:      fire = any_wr;
    endcase
  end

  assign commit = fire && (touched_q || any_wr);

  if (BUFFERED) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q   <= '0;
        mask_q    <= '0;
        touched_q <= 1'b0;
      end else if (commit) begin
        mask_q    <= '0;
        touched_q <= 1'b0;
      end else if (any_wr) begin
        stage_q   <= data_now;
        mask_q    <= mask_now;
        touched_q <= 1'b1;
      end
    end
  end else begin : g_bypass
    assign stage_q   = '0;
    assign mask_q    = '0;
    assign touched_q = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= '0;
      acc_o <= 1'b0;
      mod_o <= 1'b0;
    end else begin
      if (commit) q_o <= (q_o & ~mask_now) | (data_now & mask_now);
      acc_o <= commit;
      mod_o <= commit && (|mask_now);
    end
  end

  // R7: the value never changes without an access pulse in the same cycle
  p_change_pulses_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(q_o) |-> acc_o);

  if (BUFFERED) begin : g_chk
    // R1: without the trigger the committed value holds
    p_hold_until_fire_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fire |=> $stable(q_o));
    // R5: a trigger on an empty buffer does nothing
    p_empty_trigger_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire && !touched_q && !any_wr) |=> (!acc_o && $stable(q_o)));
    // R7: a buffered write that does not commit gives no pulse
    p_no_pulse_on_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (any_wr && !fire) |=> !acc_o);
    // R6: a commit leaves no pending bits behind
    p_mask_cleared_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire && (touched_q || any_wr)) |=> (mask_q == '0 && !touched_q));
  end else begin : g_chk_direct
    // R8: an unbuffered write always gives the access pulse next cycle
    p_direct_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_wr |=> acc_o);
  end
endmodule

// File: rtl/wbuf_readmux.sv
module wbuf_readmux
  import wbuf_pkg::*;
#(
  parameter int NREG = 5,
  parameter int AW   = 4
) (
  input  logic [AW-1:0]         rd_addr_i,
  input  logic [NREG*REG_W-1:0] regs_i,
  input  logic [BUS_W-1:0]      go_i,
  output logic [BUS_W-1:0]      rd_data_o
);
  localparam int GO_ADDR = 2 * NREG;

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NREG; k++) begin
      if (rd_addr_i == AW'(2 * k))     rd_data_o = regs_i[k*REG_W +: BUS_W];
      if (rd_addr_i == AW'(2 * k + 1)) rd_data_o = regs_i[k*REG_W + BUS_W +: BUS_W];
    end
    if (rd_addr_i == AW'(GO_ADDR)) rd_data_o = go_i;
  end
endmodule

// File: rtl/wbuf_regstage.sv
module wbuf_regstage
  import wbuf_pkg::*;
#(
  parameter int              NREG         = 5,
  parameter logic [2*NREG-1:0] MODES      = 10'b00_11_10_10_01,
  parameter bit              EXT_ACT_HIGH = 1'b0,
  localparam int             AW           = $clog2(2 * NREG + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_valid_i,
  output logic                  wr_ready_o,
  input  logic [AW-1:0]         wr_addr_i,
  input  logic [BUS_W-1:0]      wr_data_i,
  input  logic [STRB_W-1:0]     wr_strb_i,
  input  logic [AW-1:0]         rd_addr_i,
  output logic [BUS_W-1:0]      rd_data_o,
  input  logic                  ext_trig_i,
  output logic [BUS_W-1:0]      go_q_o,
  output logic [NREG*REG_W-1:0] reg_q_o,
  output logic [NREG-1:0]       sw_acc_o,
  output logic [NREG-1:0]       sw_mod_o
);
  logic [NREG-1:0] lo_hit, hi_hit;
  logic            go_hit, ext_act;

  assign wr_ready_o = 1'b1;
  assign ext_act    = EXT_ACT_HIGH ? ext_trig_i : ~ext_trig_i;

  wbuf_decode #(.NREG(NREG), .AW(AW)) u_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wr_addr_i  (wr_addr_i),
    .lo_hit_o   (lo_hit),
    .hi_hit_o   (hi_hit),
    .go_hit_o   (go_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q_o <= '0;
    end else if (go_hit) begin
      for (int b = 0; b < STRB_W; b++)
        if (wr_strb_i[b]) go_q_o[8*b +: 8] <= wr_data_i[8*b +: 8];
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : g_slot
    localparam trig_mode_e M = trig_mode_e'(MODES[2*k +: 2]);
    wbuf_slot #(.MODE(M)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lo_wr_i (lo_hit[k]),
      .hi_wr_i (hi_hit[k]),
      .data_i  (wr_data_i),
      .strb_i  (wr_strb_i),
      .go_i    (go_hit),
      .ext_i   (ext_act),
      .q_o     (reg_q_o[k*REG_W +: REG_W]),
      .acc_o   (sw_acc_o[k]),
      .mod_o   (sw_mod_o[k])
    );
  end

  wbuf_readmux #(.NREG(NREG), .AW(AW)) u_readmux (
    .rd_addr_i (rd_addr_i),
    .regs_i    (reg_q_o),
    .go_i      (go_q_o),
    .rd_data_o (rd_data_o)
  );

  // R3: the trigger register changes only on a write to its own address
  p_go_only_on_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !go_hit |=> $stable(go_q_o));
endmodule

// File: tb/wbuf_regstage_tb_top.sv
`timescale 1ns/1ps
module wbuf_regstage_tb_top;
  localparam int NREG = 5;
  localparam int AW   = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 wr_valid = 1'b0, wr_ready;
  logic [AW-1:0]        wr_addr = '0, rd_addr = '0;
  logic [31:0]          wr_data = '0, rd_data, go_q;
  logic [3:0]           wr_strb = '0;
  logic                 ext_trig = 1'b1;
  logic [NREG*64-1:0]   reg_q;
  logic [NREG-1:0]      sw_acc, sw_mod;

  always #4 clk = ~clk;

  wbuf_regstage #(.NREG(NREG)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_strb_i(wr_strb),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .ext_trig_i(ext_trig),
    .go_q_o(go_q), .reg_q_o(reg_q), .sw_acc_o(sw_acc), .sw_mod_o(sw_mod)
  );

  typedef struct {
    int          due;
    int          kind;
    int          idx;
    logic [63:0] val;
    logic        acc;
    logic        mod;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          cyc = 0, n_chk = 0, n_fail = 0;
  bit          done = 1'b0;
  logic        ext_lvl = 1'b1;
  logic [3:0]  rd_sel = '0;

  task automatic check(input exp_t e);
    n_chk++;
    case (e.kind)
      0: if (reg_q[e.idx*64 +: 64] !== e.val || sw_acc[e.idx] !== e.acc || sw_mod[e.idx] !== e.mod) begin
           n_fail++;
           $display("FAIL %s: reg%0d q=%h acc=%b mod=%b, expected q=%h acc=%b mod=%b", e.tag, e.idx,
                    reg_q[e.idx*64 +: 64], sw_acc[e.idx], sw_mod[e.idx], e.val, e.acc, e.mod);
         end
      1: if (rd_data !== e.val[31:0]) begin
           n_fail++;
           $display("FAIL %s: rd_data=%h, expected %h", e.tag, rd_data, e.val[31:0]);
         end
      default: if (wr_ready !== e.acc) begin
           n_fail++;
           $display("FAIL %s: wr_ready=%b, expected %b", e.tag, wr_ready, e.acc);
         end
    endcase
  endtask

  // monitor: samples 2 ns after each rising edge, pops items due by then
  always @(posedge clk) begin
    exp_t e;
    cyc++;
    #2;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      e = sb.pop_front();
      check(e);
    end
  end

  task automatic op(input bit v, input logic [3:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    wr_valid = v; wr_addr = a; wr_data = d; wr_strb = s;
    ext_trig = ext_lvl; rd_addr = rd_sel;
  endtask
  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s);
    op(1'b1, a, d, s);
  endtask
  task automatic idle();
    op(1'b0, 4'd0, 32'd0, 4'd0);
  endtask
  task automatic exp_reg(input int idx, input logic [63:0] v, input logic a, input logic m, input string tag);
    sb.push_back('{cyc + 1, 0, idx, v, a, m, tag});
  endtask
  task automatic exp_rd(input logic [31:0] v, input string tag);
    sb.push_back('{cyc + 1, 1, 0, {32'd0, v}, 1'b0, 1'b0, tag});
  endtask
  task automatic exp_rdy(input string tag);
    sb.push_back('{cyc + 1, 2, 0, 64'd0, 1'b1, 1'b0, tag});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    idle();
    for (int k = 0; k < NREG; k++) exp_reg(k, 64'd0, 1'b0, 1'b0, "R10 reset value");
    exp_rdy("R11 ready");

    // R1/R2/R7/R9 own-top mode on reg0
    wr(4'd0, 32'h11111111, 4'hF);
    exp_reg(0, 64'd0, 1'b0, 1'b0, "R1 lower write held");
    idle();
    exp_reg(0, 64'd0, 1'b0, 1'b0, "R7 no pulse after buffered write");
    exp_rd(32'd0, "R9 staged data not readable");
    wr(4'd1, 32'h22222222, 4'hF);
    exp_reg(0, 64'h22222222_11111111, 1'b1, 1'b1, "R2 atomic commit");
    exp_rd(32'h11111111, "R9 committed lower word");
    rd_sel = 4'd1;
    idle();
    exp_reg(0, 64'h22222222_11111111, 1'b0, 1'b0, "R7 single-cycle pulse");
    exp_rd(32'h22222222, "R9 committed upper word");

    // R6 partial and overlapping writes
    wr(4'd0, 32'hAAAAAAAA, 4'b0001);
    exp_reg(0, 64'h22222222_11111111, 1'b0, 1'b0, "R1 partial write held");
    wr(4'd0, 32'hBBBBBBBB, 4'b0011);
    wr(4'd1, 32'hCCCCCCCC, 4'b1000);
    exp_reg(0, 64'hCC222222_1111BBBB, 1'b1, 1'b1, "R6 per-bit merge");

    // R11 write without valid
    op(1'b0, 4'd1, 32'hFFFFFFFF, 4'hF);
    exp_reg(0, 64'hCC222222_1111BBBB, 1'b0, 1'b0, "R11 no valid no effect");
    exp_rdy("R11 ready during traffic");

    // R5 trigger register hit with empty buffers, R3 trigger register storage
    rd_sel = 4'd10;
    wr(4'd10, 32'h00000005, 4'hF);
    exp_reg(1, 64'd0, 1'b0, 1'b0, "R5 empty trigger reg1");
    exp_reg(2, 64'd0, 1'b0, 1'b0, "R5 empty trigger reg2");
    exp_rd(32'h00000005, "R3 trigger register readback");

    // R3 group commit
    wr(4'd2, 32'h01020304, 4'hF);
    exp_reg(1, 64'd0, 1'b0, 1'b0, "R1 reg1 lower held");
    wr(4'd3, 32'hFFFF0000, 4'hF);
    exp_reg(1, 64'd0, 1'b0, 1'b0, "R3 upper word does not commit");
    wr(4'd5, 32'h0A0B0C0D, 4'hF);
    exp_reg(2, 64'd0, 1'b0, 1'b0, "R1 reg2 upper held");
    wr(4'd10, 32'h0, 4'h0);
    exp_reg(1, 64'hFFFF0000_01020304, 1'b1, 1'b1, "R3 group commit reg1");
    exp_reg(2, 64'h0A0B0C0D_00000000, 1'b1, 1'b1, "R3 group commit reg2");
    exp_rd(32'h00000005, "R3 zero-strobe trigger keeps value");

    // R4 external pin, active low
    wr(4'd6, 32'h12345678, 4'hF);
    exp_reg(3, 64'd0, 1'b0, 1'b0, "R4 inactive level");
    ext_lvl = 1'b0;
    wr(4'd7, 32'h9ABCDEF0, 4'hF);
    exp_reg(3, 64'h9ABCDEF0_12345678, 1'b1, 1'b1, "R4 pin commit with same-edge write");
    idle();
    exp_reg(3, 64'h9ABCDEF0_12345678, 1'b0, 1'b0, "R5 held pin nothing pending");
    ext_lvl = 1'b1;

    // R8 unbuffered register
    wr(4'd8, 32'hDEADBEEF, 4'b0101);
    exp_reg(4, 64'h00000000_00AD00EF, 1'b1, 1'b1, "R8 immediate write");
    wr(4'd9, 32'hFFFFFFFF, 4'b0000);
    exp_reg(4, 64'h00000000_00AD00EF, 1'b1, 1'b0, "R7 zero-strobe access");

    // R10 reset drops staged data
    wr(4'd2, 32'h77777777, 4'hF);
    exp_reg(1, 64'hFFFF0000_01020304, 1'b0, 1'b0, "R1 staged before reset");
    idle();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    idle();
    for (int k = 0; k < NREG; k++) exp_reg(k, 64'd0, 1'b0, 1'b0, "R10 cleared by reset");
    exp_rd(32'd0, "R10 trigger register cleared");
    wr(4'd10, 32'h0, 4'hF);
    exp_reg(1, 64'd0, 1'b0, 1'b0, "R10 stale staging not committed");

    repeat (3) idle();
    if (sb.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run still active at %0d cycles, expected completion", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule